// File: doc/BRIEF.md
# Cache Way Maintenance Sequencer

This block holds the line state of a small two-way cache and carries out whole-way maintenance when software asks for it. Software writes one 32-bit control word. The word holds four policy bits, four per-way request bits and a start bit. The policy bits leave the block as plain enable levels for the rest of the cache. When the start bit is written, the sequencer visits every line of both ways in a fixed order. For a way whose invalidate request is set, it drops each line. For a way whose push request is set, it writes each modified line back to memory.

Write-backs leave on a valid/ready stream. Once the sequencer raises `mem_valid`, it keeps the beat (address and data) unchanged until `mem_ready` is seen high on a clock edge. `mem_ready` may stay low for any number of cycles. The walk stalls on that line until the beat is taken, and the walk has no other side effects while it waits. While the walk runs, the start bit reads back as 1, so software polls the same register for completion. A plain load port fills lines, and a plain probe port reads the valid and modified state of any line. Both ports stand in for the cache's normal fill path, which is outside this block.

Top module: `way_maint_seq`

## Requirements
- R1: After reset, the control word reads 0, all four policy outputs are low, `mem_valid` is low and every line of both ways probes as invalid and unmodified.
- R2: A control write updates the policy outputs at any time. Bit 0 drives `cache_en`, bit 1 drives `wbuf_en` and bit 2 drives `force_wt`. `no_alloc` is high only while both bit 3 and bit 2 are set. Bits 3:0 and 27:24 read back as written, and bits 30:28 and 23:4 read 0.
- R3: A write with bit 31 set while idle starts a walk, and bit 31 reads 1 from the next cycle until the walk ends. A write with bit 31 clear starts nothing and produces no memory write.
- R4: Bit 24 (way 0) and bit 26 (way 1) request invalidation. After the walk, every line of a requested way probes invalid and unmodified, and the lines of the other way keep their state.
- R5: Bit 25 (way 0) and bit 27 (way 1) request a push. Each line of a requested way that is both valid and modified is written once. Its address is the zero-extended value {tag, index, 2'b00} and its data is the line data. After the write, the line stays valid and probes unmodified.
- R6: A push writes nothing for a line that is invalid, or for a line that is valid but not modified.
- R7: When push and invalidate are both requested for one way, each modified line is written back before it is dropped. Every line of that way then probes invalid.
- R8: Write-backs leave in walk order: all of way 0 before way 1, with the index ascending within each way.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold. A beat counts only on a cycle where both are high, so no beat is lost or repeated under back-pressure.
- R10: A control write during a walk leaves bits 27:24 and the running walk unchanged, and its bit 31 starts nothing. The same write still updates the policy bits.
- R11: The load port sets a line valid with the given tag, data and modified flag, but only while idle. A load issued during a walk has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write value |
| cfg_rdata | output | 32 | Control word readback, with bit 31 as the busy flag |
| cache_en | output | 1 | Cache enable level |
| wbuf_en | output | 1 | Write buffer enable level |
| force_wt | output | 1 | Force write-through level |
| no_alloc | output | 1 | No allocation on miss (requires force_wt) |
| ld_en | input | 1 | Line load strobe |
| ld_way | input | 1 | Way of the line to load |
| ld_idx | input | IDX_W | Index of the line to load |
| ld_tag | input | TAG_W | Tag to load |
| ld_data | input | DATA_W | Data to load |
| ld_dirty | input | 1 | Modified flag to load |
| pr_way | input | 1 | Probe way |
| pr_idx | input | IDX_W | Probe index |
| pr_valid | output | 1 | Valid state of the probed line |
| pr_dirty | output | 1 | Modified state of the probed line |
| mem_valid | output | 1 | Write-back beat valid |
| mem_ready | input | 1 | Write-back beat accepted |
| mem_addr | output | ADDR_W | Write-back byte address |
| mem_data | output | DATA_W | Write-back data |

## Verification
The bench mixes clean, modified and empty lines in both ways, then compares the write-back stream with a model of the line state, beat for beat. A sequencer that pushes clean or empty lines produces extra beats. One that walks way 1 first or runs the index downward produces beats out of order. A combined push-and-invalidate that drops a line before writing it loses that line's beat.

Two kinds of back-pressure are applied: `mem_ready` toggling every cycle, and `mem_ready` high only one cycle in four. A design that advances without the handshake drops beats, and one that ignores the handshake repeats them. A start written mid-walk with different request bits checks that the running walk keeps its own requests while the policy bits still move. Loads during a walk check that line state cannot change under the sequencer.

// File: rtl/way_maint_pkg.sv
package way_maint_pkg;
  localparam int CW_W      = 32;
  localparam int CW_GO     = 31;
  localparam int CW_REQ_LO = 24;
  localparam int REQ_W     = 4;
  localparam int POL_W     = 4;

  typedef enum logic [1:0] {
    WM_IDLE = 2'd0,
    WM_SCAN = 2'd1,
    WM_PUSH = 2'd2
  } wm_state_t;
endpackage

// File: rtl/way_ctrl_reg.sv
module way_ctrl_reg
  import way_maint_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CW_W-1:0]  cfg_wdata,
  input  logic             busy,
  output logic [CW_W-1:0]  cfg_rdata,
  output logic             start,
  output logic [REQ_W-1:0] req,
  output logic             cache_en,
  output logic             wbuf_en,
  output logic             force_wt,
  output logic             no_alloc
);
  logic [POL_W-1:0] pol_q;
  logic [REQ_W-1:0] req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q <= '0;
      req_q <= '0;
    end else if (cfg_wr) begin
      pol_q <= cfg_wdata[POL_W-1:0];
      if (!busy) req_q <= cfg_wdata[CW_REQ_LO +: REQ_W];
    end
  end

  assign start    = cfg_wr && cfg_wdata[CW_GO] && !busy;
  assign req      = req_q;
  assign cache_en = pol_q[0];
  assign wbuf_en  = pol_q[1];
  assign force_wt = pol_q[2];
  assign no_alloc = pol_q[3] && pol_q[2];

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[POL_W-1:0]           = pol_q;
    cfg_rdata[CW_REQ_LO +: REQ_W]  = req_q;
    cfg_rdata[CW_GO]               = busy;
  end

  AST_POLICY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cache_en == $past(cfg_wdata[0])) && (force_wt == $past(cfg_wdata[2]))); // R2
endmodule

// File: rtl/way_line_store.sv
module way_line_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic              ld_way,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_dirty,
  input  logic              wk_way,
  input  logic [IDX_W-1:0]  wk_idx,
  input  logic              wk_clr_valid,
  input  logic              wk_clr_dirty,
  output logic              wk_valid,
  output logic              wk_dirty,
  output logic [TAG_W-1:0]  wk_tag,
  output logic [DATA_W-1:0] wk_data,
  input  logic              pr_way,
  input  logic [IDX_W-1:0]  pr_idx,
  output logic              pr_valid,
  output logic              pr_dirty
);
  localparam int ENTRIES = 2 << IDX_W;
  localparam int SEL_W   = IDX_W + 1;

  logic [ENTRIES-1:0] valid_q, dirty_q, valid_d, dirty_d;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [SEL_W-1:0]   ld_sel, wk_sel, pr_sel;

  assign ld_sel = {ld_way, ld_idx};
  assign wk_sel = {wk_way, wk_idx};
  assign pr_sel = {pr_way, pr_idx};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_line
    logic hit_ld, hit_wk;
    assign hit_ld = ld_en && (ld_sel == SEL_W'(e));
    assign hit_wk = wk_sel == SEL_W'(e);
    assign valid_d[e] = hit_ld ? 1'b1 :
                        (hit_wk && wk_clr_valid) ? 1'b0 : valid_q[e];
    assign dirty_d[e] = hit_ld ? ld_dirty :
                        (hit_wk && (wk_clr_valid || wk_clr_dirty)) ? 1'b0 : dirty_q[e];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      tag_q[ld_sel]  <= ld_tag;
      data_q[ld_sel] <= ld_data;
    end
  end

  assign wk_valid = valid_q[wk_sel];
  assign wk_dirty = dirty_q[wk_sel];
  assign wk_tag   = tag_q[wk_sel];
  assign wk_data  = data_q[wk_sel];
  assign pr_valid = valid_q[pr_sel];
  assign pr_dirty = dirty_q[pr_sel];

  AST_DIRTY_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wk_dirty |-> wk_valid); // R4
endmodule

// File: rtl/way_walker.sv
module way_walker
  import way_maint_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REQ_W-1:0]  req,
  output logic              busy,
  output logic              cur_way,
  output logic [IDX_W-1:0]  cur_idx,
  input  logic              line_valid,
  input  logic              line_dirty,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              clr_valid,
  output logic              clr_dirty,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);
  localparam int LINE_AW = TAG_W + IDX_W + 2;

  wm_state_t        st_q, st_d;
  logic             way_q;
  logic [IDX_W-1:0] idx_q;
  logic             want_inv, want_push, advance, last_line;

  assign want_inv  = req[{way_q, 1'b0}];
  assign want_push = req[{way_q, 1'b1}];
  assign last_line = way_q && (idx_q == '1);

  always_comb begin
    st_d      = st_q;
    advance   = 1'b0;
    clr_valid = 1'b0;
    clr_dirty = 1'b0;
    unique case (st_q)
      WM_IDLE: if (start) st_d = WM_SCAN;
      WM_SCAN: begin
        if (want_push && line_valid && line_dirty) begin
          st_d = WM_PUSH;
        end else begin
          clr_valid = want_inv;
          advance   = 1'b1;
        end
      end
      WM_PUSH: begin
        if (mem_ready) begin
          clr_dirty = 1'b1;
          clr_valid = want_inv;
          advance   = 1'b1;
          st_d      = WM_SCAN;
        end
      end
      default: st_d = WM_IDLE;
    endcase
    if (advance && last_line) st_d = WM_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= WM_IDLE;
      way_q <= 1'b0;
      idx_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == WM_IDLE && start) begin
        way_q <= 1'b0;
        idx_q <= '0;
      end else if (advance) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == '1) way_q <= 1'b1;
      end
    end
  end

  assign busy      = st_q != WM_IDLE;
  assign cur_way   = way_q;
  assign cur_idx   = idx_q;
  assign mem_valid = st_q == WM_PUSH;
  assign mem_addr  = ADDR_W'({line_tag, idx_q, 2'b00});
  assign mem_data  = line_data;

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R9
  AST_PUSH_ONLY_MODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> line_valid && line_dirty); // R6
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid && !clr_valid && !clr_dirty); // R3
endmodule

// File: rtl/way_maint_seq.sv
module way_maint_seq
  import way_maint_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              cache_en,
  output logic              wbuf_en,
  output logic              force_wt,
  output logic              no_alloc,
  input  logic              ld_en,
  input  logic              ld_way,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_dirty,
  input  logic              pr_way,
  input  logic [IDX_W-1:0]  pr_idx,
  output logic              pr_valid,
  output logic              pr_dirty,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);
  logic             busy, start, clr_valid, clr_dirty;
  logic [REQ_W-1:0] req;
  logic             cur_way, line_valid, line_dirty;
  logic [IDX_W-1:0] cur_idx;
  logic [TAG_W-1:0] line_tag;
  logic [DATA_W-1:0] line_data;

  way_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .busy(busy), .cfg_rdata(cfg_rdata), .start(start), .req(req),
    .cache_en(cache_en), .wbuf_en(wbuf_en), .force_wt(force_wt),
    .no_alloc(no_alloc)
  );

  way_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en && !busy), .ld_way(ld_way), .ld_idx(ld_idx),
    .ld_tag(ld_tag), .ld_data(ld_data), .ld_dirty(ld_dirty),
    .wk_way(cur_way), .wk_idx(cur_idx),
    .wk_clr_valid(clr_valid), .wk_clr_dirty(clr_dirty),
    .wk_valid(line_valid), .wk_dirty(line_dirty),
    .wk_tag(line_tag), .wk_data(line_data),
    .pr_way(pr_way), .pr_idx(pr_idx), .pr_valid(pr_valid), .pr_dirty(pr_dirty)
  );

  way_walker #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .req(req), .busy(busy),
    .cur_way(cur_way), .cur_idx(cur_idx),
    .line_valid(line_valid), .line_dirty(line_dirty),
    .line_tag(line_tag), .line_data(line_data),
    .clr_valid(clr_valid), .clr_dirty(clr_dirty),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  AST_REQ_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31] && cfg_wr |=> cfg_rdata[27:24] == $past(cfg_rdata[27:24])); // R10
endmodule

// File: tb/test_way_maint_seq.sv
module test_way_maint_seq;
  localparam int IDX_W = 3, TAG_W = 8, DATA_W = 32, ADDR_W = 32;
  localparam int NL = 1 << IDX_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic cache_en, wbuf_en, force_wt, no_alloc;
  logic ld_en = 1'b0, ld_way = 1'b0, ld_dirty = 1'b0;
  logic [IDX_W-1:0] ld_idx = '0, pr_idx = '0;
  logic [TAG_W-1:0] ld_tag = '0;
  logic [DATA_W-1:0] ld_data = '0, mem_data;
  logic pr_way = 1'b0, pr_valid, pr_dirty;
  logic mem_valid, mem_ready = 1'b1;
  logic [ADDR_W-1:0] mem_addr;

  always #5 clk = ~clk;

  way_maint_seq #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_way_maint_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cache_en(cache_en), .wbuf_en(wbuf_en), .force_wt(force_wt), .no_alloc(no_alloc),
    .ld_en(ld_en), .ld_way(ld_way), .ld_idx(ld_idx), .ld_tag(ld_tag), .ld_data(ld_data),
    .ld_dirty(ld_dirty), .pr_way(pr_way), .pr_idx(pr_idx), .pr_valid(pr_valid),
    .pr_dirty(pr_dirty), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, rdy_mode = 0;
  logic m_v [2][NL];
  logic m_d [2][NL];
  logic [TAG_W-1:0] m_t [2][NL];
  logic [DATA_W-1:0] m_x [2][NL];
  logic [ADDR_W-1:0] cap_a [64];
  logic [DATA_W-1:0] cap_d [64];
  int cap_n = 0;
  logic [ADDR_W-1:0] exp_a [64];
  logic [DATA_W-1:0] exp_d [64];
  int exp_n = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    case (rdy_mode)
      0: mem_ready <= 1'b1;
      1: mem_ready <= cyc[0];
      default: mem_ready <= (cyc[1:0] == 2'b11);
    endcase
  end

  always @(posedge clk)
    if (rst_n && mem_valid && mem_ready && cap_n < 64) begin
      cap_a[cap_n] = mem_addr;
      cap_d[cap_n] = mem_data;
      cap_n = cap_n + 1;
    end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic cfg_write(input logic [31:0] w);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic load(input bit w, input int i, input logic [TAG_W-1:0] t,
                      input logic [DATA_W-1:0] x, input bit d);
    @(negedge clk);
    ld_en = 1'b1; ld_way = w; ld_idx = IDX_W'(i); ld_tag = t; ld_data = x; ld_dirty = d;
    @(negedge clk); ld_en = 1'b0;
    m_v[w][i] = 1'b1; m_d[w][i] = d; m_t[w][i] = t; m_x[w][i] = x;
  endtask

  task automatic wait_idle(input string rq);
    int n = 0;
    while (cfg_rdata[31] && n < 2000) begin @(negedge clk); n++; end
    chk(!cfg_rdata[31], rq, 64'(cfg_rdata[31]), 64'd0);
  endtask

  // model of a walk: builds expected beats and updates line state
  task automatic model_walk(input logic [3:0] rq);
    exp_n = 0;
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < NL; i++) begin
        if (rq[2*w+1] && m_v[w][i] && m_d[w][i]) begin
          exp_a[exp_n] = ADDR_W'({m_t[w][i], IDX_W'(i), 2'b00});
          exp_d[exp_n] = m_x[w][i];
          exp_n++;
          m_d[w][i] = 1'b0;
        end
        if (rq[2*w]) begin m_v[w][i] = 1'b0; m_d[w][i] = 1'b0; end
      end
  endtask

  task automatic compare_beats(input string rq);
    chk(cap_n == exp_n, rq, 64'(cap_n), 64'(exp_n));
    for (int k = 0; k < exp_n && k < cap_n; k++) begin
      chk(cap_a[k] == exp_a[k], rq, 64'(cap_a[k]), 64'(exp_a[k]));
      chk(cap_d[k] == exp_d[k], rq, 64'(cap_d[k]), 64'(exp_d[k]));
    end
  endtask

  task automatic compare_lines(input string rq);
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < NL; i++) begin
        @(negedge clk); pr_way = w[0]; pr_idx = IDX_W'(i); #1;
        chk(pr_valid == m_v[w][i] && pr_dirty == m_d[w][i], rq,
            64'({pr_valid, pr_dirty}), 64'({m_v[w][i], m_d[w][i]}));
      end
  endtask

  task automatic run_walk(input logic [3:0] rq, input string tag);
    cap_n = 0;
    model_walk(rq);
    cfg_write({1'b1, 3'b0, rq, 20'h0, 4'h0});
    chk(cfg_rdata[31] == 1'b1, "R3", 64'(cfg_rdata[31]), 64'd1);
    wait_idle(tag);
    compare_beats(tag);
    compare_lines(tag);
  endtask

  task automatic fill_mix();
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < NL; i++)
        if (i % 3 != 2) load(w[0], i, TAG_W'(8'h30 + 16*w + i), 32'hA000_0000 + 32'(w*256 + i*17), (i % 3) == 0);
  endtask

  task automatic t_reset();
    chk(cfg_rdata == 32'h0, "R1", 64'(cfg_rdata), 64'd0);
    chk({cache_en, wbuf_en, force_wt, no_alloc} == 4'b0, "R1", 64'({cache_en, wbuf_en, force_wt, no_alloc}), 64'd0);
    chk(!mem_valid, "R1", 64'(mem_valid), 64'd0);
    compare_lines("R1");
  endtask

  task automatic t_policy();
    cfg_write(32'h7FFF_FFF8);
    chk(no_alloc == 1'b0 && force_wt == 1'b0, "R2 no_alloc needs bit2", 64'({no_alloc, force_wt}), 64'd0);
    chk(cfg_rdata == 32'h0F00_0008, "R2 readback", 64'(cfg_rdata), 64'h0F00_0008);
    cfg_write(32'h0000_000C);
    chk(no_alloc && force_wt && !cache_en && !wbuf_en, "R2", 64'({cache_en, wbuf_en, force_wt, no_alloc}), 64'h3);
    cfg_write(32'h0000_0003);
    chk(cache_en && wbuf_en && !force_wt && !no_alloc, "R2", 64'({cache_en, wbuf_en, force_wt, no_alloc}), 64'hC);
  endtask

  task automatic t_no_go();
    fill_mix();
    cap_n = 0;
    cfg_write(32'h0F00_0000);
    chk(cfg_rdata[31] == 1'b0, "R3 no start", 64'(cfg_rdata[31]), 64'd0);
    repeat (30) @(negedge clk);
    chk(cap_n == 0, "R3 no beats", 64'(cap_n), 64'd0);
    compare_lines("R3");
  endtask

  task automatic t_push_way0();
    rdy_mode = 0;
    run_walk(4'b0010, "R5 R6 push way0");
  endtask

  task automatic t_push_both();
    fill_mix();
    rdy_mode = 0;
    run_walk(4'b1010, "R8 order both ways");
  endtask

  task automatic t_inv_way1();
    fill_mix();
    run_walk(4'b0100, "R4 invalidate way1");
  endtask

  task automatic t_push_inv();
    fill_mix();
    run_walk(4'b0011, "R7 push+inv way0");
    run_walk(4'b1100, "R7 push+inv way1");
  endtask

  task automatic t_backpressure();
    fill_mix();
    rdy_mode = 1;
    run_walk(4'b1010, "R9 toggling ready");
    fill_mix();
    rdy_mode = 2;
    run_walk(4'b1111, "R9 sparse ready");
    rdy_mode = 0;
  endtask

  task automatic t_busy_write();
    fill_mix();
    rdy_mode = 2;
    cap_n = 0;
    model_walk(4'b0010);
    cfg_write(32'h8200_0000);
    repeat (3) @(negedge clk);
    chk(cfg_rdata[31] == 1'b1, "R10 still busy", 64'(cfg_rdata[31]), 64'd1);
    cfg_write(32'h8D00_0005);
    chk(cache_en && force_wt && !wbuf_en, "R10 policy updates", 64'({cache_en, wbuf_en, force_wt}), 64'h5);
    chk(cfg_rdata[27:24] == 4'b0010, "R10 request held", 64'(cfg_rdata[27:24]), 64'h2);
    // R11: load during walk has no effect
    @(negedge clk);
    ld_en = 1'b1; ld_way = 1'b1; ld_idx = IDX_W'(2); ld_tag = 8'hEE; ld_data = 32'hDEAD; ld_dirty = 1'b1;
    @(negedge clk); ld_en = 1'b0;
    wait_idle("R10");
    compare_beats("R10 walk unchanged");
    repeat (20) @(negedge clk);
    chk(cfg_rdata[31] == 1'b0, "R10 no restart", 64'(cfg_rdata[31]), 64'd0);
    compare_lines("R11 load ignored while busy");
    rdy_mode = 0;
  endtask

  task automatic t_load_idle();
    load(1'b1, 2, 8'h5A, 32'h1234_5678, 1'b1);
    compare_lines("R11 load while idle");
    cap_n = 0;
    run_walk(4'b1000, "R11 loaded line pushed");
  endtask

  initial begin
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < NL; i++) begin
        m_v[w][i] = 1'b0; m_d[w][i] = 1'b0; m_t[w][i] = '0; m_x[w][i] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_policy();
    t_no_go();
    t_push_way0();
    t_push_both();
    t_inv_way1();
    t_push_inv();
    t_backpressure();
    t_busy_write();
    t_load_idle();
    finish_run();
  end
endmodule